// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block is the host side of a three-wire serial link to a 16-bit-word serial EEPROM. It drives chip select, a serial clock and the data line into the memory, and it samples the memory's data-out line. A command port accepts one operation at a time: read, write, erase one word, erase all, write all, enable programming or disable programming. Each operation comes with an address and, where needed, a data word. The block serialises the command, collects read data, and supervises the self-timed programming cycle. It ends each command with one response word and an error flag.

A programming command is finished by dropping chip select. Chip select is then raised again after a minimum low time, and the block watches the data-out line until the memory reports ready. A timeout stops the wait and sets the error flag. All serial timing is counted in system clock cycles. The parameter defaults meet the memory's limits at a 250 MHz system clock: a 1 µs serial clock period, 500 ns high and low phases, and 300 ns minimum chip-select low time.

The command port and the response port are valid/ready. A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the block is idle. A response stays on `rsp_valid` with stable contents until `rsp_ready` is high. Until then no new command is taken, so a slow consumer stalls the command side.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is asserted and right after it, `mw_cs`, `mw_sk` and `mw_di` are low, `cmd_ready` is high, and `rsp_valid` and `busy` are low.
- R2: Every command raises `mw_cs` and sends a 1 start bit, then a 2-bit opcode, then ADDR_W address bits, all MSB first. The opcode is 10 for read, 01 for write, 11 for erase, and 00 for the rest. The `cmd_op` codes are: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 program-enable, 6 program-disable; 7 acts as program-disable. A command that carries no data gives exactly 9 rising serial clock edges.
- R3: For opcode 00, the top two address bits select the action and the remaining address bits are 0. The selections are 11 program-enable, 00 program-disable, 10 erase-all and 01 write-all. After a program-disable, a write leaves the stored word unchanged.
- R4: A read gives 26 rising edges. The first bit returned after the address is discarded. The next 16 bits, MSB first, appear on `rsp_rdata`. Responses to commands other than read carry `rsp_rdata` = 0.
- R5: Write and write-all append the 16-bit `cmd_wdata` MSB first after the address (25 rising edges), and then drop `mw_cs`.
- R6: Write, erase, erase-all and write-all are the programming commands. After one of them, `mw_cs` stays low for CS_LO_CYC cycles and then rises with `mw_sk` held low. After STAT_CYC further cycles, `mw_do` is sampled every cycle. A high sample ends the command with `rsp_err` = 0.
- R7: If `mw_do` stays low for TIMEOUT_CYC polling cycles, the command ends with `rsp_err` = 1 and `mw_cs` is lowered.
- R8: Each serial bit has `mw_sk` low for at least SK_LO_CYC cycles, then high for at least SK_HI_CYC cycles. `mw_sk` is high only while `mw_cs` is high. `mw_di` changes only while `mw_sk` is low. `mw_do` is sampled through a two-stage synchroniser in the last low cycle before each rising edge.
- R9: A command is accepted only when `cmd_ready` is high. In the next cycle `busy` is high and `cmd_ready` is low. `mw_cs` is low whenever `busy` is low.
- R10: `rsp_valid` stays high with stable `rsp_rdata` and `rsp_err` until `rsp_ready` is high. While `rsp_valid` is high, `cmd_ready` is low.
- R11: Each time `mw_cs` rises, it has been low for at least CS_LO_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data for write and write-all |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | DATA_W | Read data, 0 for other commands |
| rsp_err | output | 1 | Ready polling timed out |
| busy | output | 1 | A command is on the serial link |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data into the memory |
| mw_do | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions assume a synchronous active-low reset. They also assume that `cmd_valid` and `rsp_ready` are driven in step with the system clock. They make no assumption about `mw_do`, since every serial-side property concerns only what the block drives. The bench changes its handshake inputs half a cycle away from the active edge. It models the memory as a device clocked by the serial clock and by chip-select edges, with a fixed programming time below the polling timeout. It forces a timeout only through a deliberate stuck-busy switch.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;
  typedef enum logic [2:0] {
    MW_READ      = 3'd0,
    MW_WRITE     = 3'd1,
    MW_ERASE     = 3'd2,
    MW_ERASE_ALL = 3'd3,
    MW_WRITE_ALL = 3'd4,
    MW_WREN      = 3'd5,
    MW_WRDIS     = 3'd6
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_CSLOW, ST_STAT, ST_POLL, ST_GAP, ST_RESP
  } mw_state_e;
endpackage

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_host_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int FW = 3 + ADDR_W + DATA_W,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [FW-1:0]     frame_o,
  output logic [LW-1:0]     len_o,
  output logic              is_read_o,
  output logic              is_prog_o
);
  logic [1:0]        opc;
  logic [ADDR_W-1:0] fld;
  logic [DATA_W-1:0] dat;
  logic              has_data;

  always_comb begin
    opc       = 2'b00;
    fld       = addr_i;
    dat       = '0;
    has_data  = 1'b0;
    is_read_o = 1'b0;
    is_prog_o = 1'b0;
    case (op_i)
      MW_READ: begin
        opc       = 2'b10;
        is_read_o = 1'b1;
      end
      MW_WRITE: begin
        opc       = 2'b01;
        dat       = wdata_i;
        has_data  = 1'b1;
        is_prog_o = 1'b1;
      end
      MW_ERASE: begin
        opc       = 2'b11;
        is_prog_o = 1'b1;
      end
      MW_ERASE_ALL: begin
        fld       = {2'b10, {(ADDR_W-2){1'b0}}};
        is_prog_o = 1'b1;
      end
      MW_WRITE_ALL: begin
        fld       = {2'b01, {(ADDR_W-2){1'b0}}};
        dat       = wdata_i;
        has_data  = 1'b1;
        is_prog_o = 1'b1;
      end
      MW_WREN:  fld = {2'b11, {(ADDR_W-2){1'b0}}};
      default:  fld = {2'b00, {(ADDR_W-2){1'b0}}};
    endcase
    frame_o = {1'b1, opc, fld, dat};
    len_o   = has_data ? LW'(FW) : LW'(3 + ADDR_W);
  end
endmodule

// File: rtl/mw_bit_timer.sv
module mw_bit_timer #(
  parameter int LO_CYC = 125,
  parameter int HI_CYC = 125,
  localparam int PER = LO_CYC + HI_CYC,
  localparam int CW  = $clog2(PER)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk,
  output logic smp,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run)                  cnt <= '0;
    else if (cnt == CW'(PER - 1))   cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign sk   = run && (cnt >= CW'(LO_CYC));
  assign smp  = run && (cnt == CW'(LO_CYC - 1));
  assign last = run && (cnt == CW'(PER - 1));
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_host_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SK_LO_CYC   = 125,
  parameter int SK_HI_CYC   = 125,
  parameter int CS_LO_CYC   = 75,
  parameter int STAT_CYC    = 125,
  parameter int TIMEOUT_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              busy,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int FW   = 3 + ADDR_W + DATA_W;
  localparam int LW   = $clog2(FW + 1);
  localparam int WMAX = (CS_LO_CYC > STAT_CYC) ? CS_LO_CYC : STAT_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);

  mw_state_e         state;
  logic [FW-1:0]     shreg;
  logic [LW-1:0]     bits_left;
  logic [DATA_W-1:0] rdreg;
  logic [WW-1:0]     wcnt;
  logic [TW-1:0]     tcnt;
  logic              rd_is, pg_is, err_q, cs_q, di_q;
  logic              do_m, do_s;

  logic [FW-1:0]     f_frame;
  logic [LW-1:0]     f_len;
  logic              f_read, f_prog;
  logic              t_run, t_sk, t_smp, t_last;

  mw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) frame_i (
    .op_i(cmd_op), .addr_i(cmd_addr), .wdata_i(cmd_wdata),
    .frame_o(f_frame), .len_o(f_len), .is_read_o(f_read), .is_prog_o(f_prog)
  );

  assign t_run = (state == ST_SEND) || (state == ST_RECV);

  mw_bit_timer #(.LO_CYC(SK_LO_CYC), .HI_CYC(SK_HI_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(t_run),
    .sk(t_sk), .smp(t_smp), .last(t_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      do_m <= 1'b0;
      do_s <= 1'b0;
    end else begin
      do_m <= mw_do;
      do_s <= do_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      rdreg     <= '0;
      wcnt      <= '0;
      tcnt      <= '0;
      rd_is     <= 1'b0;
      pg_is     <= 1'b0;
      err_q     <= 1'b0;
      cs_q      <= 1'b0;
      di_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          shreg     <= f_frame;
          di_q      <= f_frame[FW-1];
          bits_left <= f_len;
          rd_is     <= f_read;
          pg_is     <= f_prog;
          rdreg     <= '0;
          err_q     <= 1'b0;
          cs_q      <= 1'b1;
          state     <= ST_SEND;
        end
        ST_SEND: if (t_last) begin
          if (bits_left == LW'(1)) begin
            di_q <= 1'b0;
            if (rd_is) begin
              bits_left <= LW'(DATA_W + 1);
              state     <= ST_RECV;
            end else begin
              cs_q  <= 1'b0;
              wcnt  <= '0;
              state <= pg_is ? ST_CSLOW : ST_GAP;
            end
          end else begin
            shreg     <= shreg << 1;
            di_q      <= shreg[FW-2];
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_RECV: begin
          if (t_smp) rdreg <= {rdreg[DATA_W-2:0], do_s};
          if (t_last) begin
            if (bits_left == LW'(1)) begin
              cs_q  <= 1'b0;
              wcnt  <= '0;
              state <= ST_GAP;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        ST_CSLOW: begin
          if (wcnt == WW'(CS_LO_CYC - 1)) begin
            cs_q  <= 1'b1;
            wcnt  <= '0;
            state <= ST_STAT;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_STAT: begin
          if (wcnt == WW'(STAT_CYC - 1)) begin
            tcnt  <= '0;
            state <= ST_POLL;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (do_s) begin
            cs_q  <= 1'b0;
            wcnt  <= '0;
            state <= ST_GAP;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            err_q <= 1'b1;
            cs_q  <= 1'b0;
            wcnt  <= '0;
            state <= ST_GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (wcnt == WW'(CS_LO_CYC - 1)) state <= ST_RESP;
          else                            wcnt  <= wcnt + 1'b1;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign busy      = (state != ST_IDLE) && (state != ST_RESP);
  assign rsp_rdata = rdreg;
  assign rsp_err   = err_q;
  assign mw_cs     = cs_q;
  assign mw_sk     = t_sk;
  assign mw_di     = di_q;
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int DW  = 16,
  parameter int HI  = 125,
  parameter int LO  = 125,
  parameter int CSL = 75
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          busy,
  input logic          mw_cs,
  input logic          mw_sk,
  input logic          mw_di
);
  localparam int HW = $clog2(HI + 1);
  localparam int LWD = $clog2(LO + 1);
  localparam int CWD = $clog2(CSL + 1);

  logic [HW-1:0]  hi_cnt;
  logic [LWD-1:0] lo_cnt;
  logic [CWD-1:0] cs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= LWD'(LO);
      cs_cnt <= CWD'(CSL);
    end else begin
      if (!mw_sk)                  hi_cnt <= '0;
      else if (hi_cnt != HW'(HI))  hi_cnt <= hi_cnt + 1'b1;
      if (mw_sk)                   lo_cnt <= '0;
      else if (lo_cnt != LWD'(LO)) lo_cnt <= lo_cnt + 1'b1;
      if (mw_cs)                   cs_cnt <= '0;
      else if (cs_cnt != CWD'(CSL)) cs_cnt <= cs_cnt + 1'b1;
    end
  end

  p_sk_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sk |-> mw_cs);
  p_di_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di));
  p_sk_high_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_sk) |-> (hi_cnt >= HW'(HI)));
  p_sk_low_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sk) |-> (lo_cnt >= LWD'(LO)));
  p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> (cs_cnt >= CWD'(CSL)));
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));
  p_idle_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mw_cs);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  p_rsp_blocks_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(
  .DW(DATA_W), .HI(SK_HI_CYC), .LO(SK_LO_CYC), .CSL(CS_LO_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .busy(busy), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di)
);

// File: tb/mw_eeprom_host_tb_top.sv
module mw_eeprom_host_tb_top;
  localparam int AW = 6, DW = 16;
  localparam int LO = 125, HI = 125, CSL = 75, TMO = 6000, PROG = 2000;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_ER = 3'd2, OP_ERAL = 3'd3,
                         OP_WRAL = 3'd4, OP_EN = 3'd5, OP_DIS = 3'd6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err, busy, mw_cs, mw_sk, mw_di, mw_do;
  logic [DW-1:0] rsp_rdata;

  mw_eeprom_host #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .busy(busy), .mw_cs(mw_cs), .mw_sk(mw_sk),
    .mw_di(mw_di), .mw_do(mw_do)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory device model ----------------
  logic [15:0] mem [64];
  logic [24:0] sr = '0;
  logic [15:0] rsr = '0;
  logic started = 0, reading = 0, dout = 0, wr_en = 0, status = 0, stuck = 0;
  int nbits = 0, last_bits = 0, prog_end = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  assign mw_do = (status && mw_cs) ? ((cyc >= prog_end) && !stuck)
                                   : (reading ? dout : 1'b0);

  always @(posedge mw_sk or negedge mw_cs) begin
    if (mw_cs) begin
      if (!started) begin
        if (mw_di) begin started = 1; nbits = 1; sr = '0; status = 0; end
      end else begin
        nbits++;
        if (reading) begin
          dout = rsr[15];
          rsr  = {rsr[14:0], 1'b0};
        end else begin
          sr = {sr[23:0], mw_di};
          if (nbits == 9 && sr[7:6] == 2'b10) begin
            reading = 1; dout = 1'b0; rsr = mem[sr[5:0]];
          end
        end
      end
    end else if (started) begin
      logic [1:0] o; logic [5:0] a; logic [15:0] d; bit prog;
      prog = 0;
      if (nbits >= 25) begin o = sr[23:22]; a = sr[21:16]; d = sr[15:0]; end
      else begin o = sr[7:6]; a = sr[5:0]; d = '0; end
      if (!reading) begin
        case (o)
          2'b01: if (nbits >= 25) begin prog = 1; if (wr_en) mem[a] = d; end
          2'b11: begin prog = 1; if (wr_en) mem[a] = 16'hFFFF; end
          2'b00: case (a[5:4])
            2'b11: wr_en = 1;
            2'b00: wr_en = 0;
            2'b10: begin prog = 1;
              if (wr_en) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF; end
            default: if (nbits >= 25) begin prog = 1;
              if (wr_en) for (int i = 0; i < 64; i++) mem[i] = d; end
          endcase
          default: ;
        endcase
      end
      if (prog) begin status = 1; if (wr_en) prog_end = cyc + PROG; end
      last_bits = nbits; started = 0; reading = 0;
    end
  end

  // ---------------- serial timing observers ----------------
  int hi_run = 0, lo_run = 1000000, cs_lo_run = 1000000;
  int min_hi = 1000000, min_lo = 1000000, min_cs_lo = 1000000, di_glitch = 0;
  logic p_sk = 0, p_cs = 0, p_di = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_sk && !p_sk && lo_run < min_lo) min_lo = lo_run;
      if (!mw_sk && p_sk && hi_run < min_hi) min_hi = hi_run;
      if (mw_cs && !p_cs && cs_lo_run < min_cs_lo) min_cs_lo = cs_lo_run;
      if (mw_sk && p_sk && mw_di != p_di) di_glitch++;
      if (mw_sk && !mw_cs) di_glitch++;
      hi_run    = mw_sk ? hi_run + 1 : 0;
      lo_run    = mw_sk ? 0 : lo_run + 1;
      cs_lo_run = mw_cs ? 0 : cs_lo_run + 1;
    end
    p_sk = mw_sk; p_cs = mw_cs; p_di = mw_di;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [15:0] rd; logic err; string tag; } exp_t;
  exp_t sb_q[$];
  logic [15:0] shadow [64];
  bit shadow_en = 0;
  int npop = 0;

  task automatic issue(input logic [2:0] op, input logic [5:0] a,
                       input logic [15:0] d, input string tag);
    exp_t e;
    bit prog;
    e.rd = '0; e.tag = tag;
    prog = (op == OP_WR) || (op == OP_ER) || (op == OP_ERAL) || (op == OP_WRAL);
    e.err = prog && stuck;
    case (op)
      OP_RD:   e.rd = shadow[a];
      OP_WR:   if (shadow_en) shadow[a] = d;
      OP_ER:   if (shadow_en) shadow[a] = 16'hFFFF;
      OP_ERAL: if (shadow_en) for (int i = 0; i < 64; i++) shadow[i] = 16'hFFFF;
      OP_WRAL: if (shadow_en) for (int i = 0; i < 64; i++) shadow[i] = d;
      OP_EN:   shadow_en = 1;
      default: shadow_en = 0;
    endcase
    sb_q.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy && !cmd_ready, "R9", "busy/ready after accept", {busy, cmd_ready}, 2'b10);
  endtask

  task automatic drain();
    while (sb_q.size() != 0 || rsp_valid || !cmd_ready) @(negedge clk);
  endtask

  task automatic expect_bits(input int n, input string req);
    drain();
    chk(last_bits == n, req, "serial rising edges", last_bits, n);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        exp_t e;
        int hold;
        hold = (npop % 2 == 1) ? 7 : 0;
        for (int k = 0; k < hold; k++) begin
          if (k == 0) chk(rsp_valid && !cmd_ready, "R10", "held response blocks commands",
                          {rsp_valid, cmd_ready}, 2'b10);
          @(negedge clk);
        end
        if (sb_q.size() == 0) begin
          chk(0, "R10", "unexpected response", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(rsp_rdata == e.rd, e.tag, "rsp_rdata", rsp_rdata, e.rd);
          chk(rsp_err == e.err, e.tag, "rsp_err", rsp_err, e.err);
        end
        npop++;
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (5) @(negedge clk);
    chk(!mw_cs && !mw_sk && !mw_di, "R1", "serial pins in reset", {mw_cs, mw_sk, mw_di}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid && !busy, "R1", "handshake after reset",
        {cmd_ready, rsp_valid, busy}, 3'b100);

    issue(OP_EN, 6'd0, '0, "R3");          expect_bits(9, "R2");
    issue(OP_WR, 6'd5, 16'hA5C3, "R6");    expect_bits(25, "R5");
    issue(OP_RD, 6'd5, '0, "R4");          expect_bits(26, "R4");
    issue(OP_ER, 6'd5, '0, "R6");          expect_bits(9, "R2");
    issue(OP_RD, 6'd5, '0, "R4");
    issue(OP_WR, 6'd63, 16'h1234, "R5");
    issue(OP_RD, 6'd63, '0, "R4");
    issue(OP_DIS, 6'd0, '0, "R3");
    issue(OP_WR, 6'd63, 16'hBEEF, "R3");
    issue(OP_RD, 6'd63, '0, "R3");
    issue(OP_EN, 6'd0, '0, "R3");
    drain();
    stuck = 1;
    issue(OP_WR, 6'd0, 16'h0F0F, "R7");
    drain();
    chk(!mw_cs, "R7", "cs low after timeout", mw_cs, 0);
    stuck = 0;
    issue(OP_WRAL, 6'd0, 16'h5AA5, "R3");  expect_bits(25, "R5");
    issue(OP_RD, 6'd17, '0, "R3");
    issue(OP_ERAL, 6'd0, '0, "R3");
    issue(OP_RD, 6'd40, '0, "R3");
    drain();

    chk(min_hi >= HI, "R8", "minimum sk high cycles", min_hi, HI);
    chk(min_lo >= LO, "R8", "minimum sk low cycles", min_lo, LO);
    chk(di_glitch == 0, "R8", "di change while sk high / sk without cs", di_glitch, 0);
    chk(min_cs_lo >= CSL, "R11", "minimum cs low cycles", min_cs_lo, CSL);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule